// File: doc/BRIEF.md
# Four-Channel Interpolating Sine Synthesizer

This block produces four independent sine waves from one shared sine table. Each channel keeps a 16-bit phase that moves forward by its own frequency step at every sample strobe. The upper eight phase bits select a table entry. The lower eight bits weight a straight-line blend between that entry and the next one. The blended value is then scaled by the channel's signed Q15 amplitude.

A simple register write port sets each channel's step, phase and amplitude. One strobe updates all four channels. The channels run through a single shared datapath, one per clock, in the order 0, 1, 2, 3. When all four samples are ready, a one-clock valid pulse marks them. At reset the channels start a quarter period apart, so the four outputs sit in quadrature.

Top module: `quad_sine_dds`

## Requirements
- R1: While reset is held, and after it is released until the first update, `valid_o` is low and all four samples read zero. Every channel's step resets to 1000 (decimal) and every amplitude resets to 0x7FFF.
- R2: On each update, a channel's phase becomes (phase + step) mod 2^16. The output is computed from this new phase. A step of zero keeps the phase, and so the sample, unchanged.
- R3: With p the new phase, i = p[15:8] and f = p[7:0], the blended value is e[i] + floor((e[i+1] − e[i]) · f / 256). This is the Q15 product of the difference and the fraction f·2^7, floored, saturated to 16 bits, and always lying between e[i] and e[i+1].
- R4: The sample equals floor(v · m / 32768), saturated to [−32768, 32767]. Here v is the blended value and m is the amplitude read as signed Q15. A negative amplitude inverts the wave, and zero silences it.
- R5: Table entry e[k] = round-half-away-from-zero(32767 · sin(2πk/256)) for k = 0..256. Entry 256 equals entry 0, so index 255 blends toward e[0].
- R6: The reset start phases are 0xC000 for channel 0, 0x0000 for channel 1, 0x4000 for channel 2 and 0x8000 for channel 3.
- R7: Call the clock edge that samples `tick_i` high while idle edge 0. Channels 0 to 3 are updated on edges 1 to 4. `valid_o` is high for exactly the one clock that follows edge 4, and all four samples then hold until the next update.
- R8: A strobe seen on edges 1 to 4 of an update in progress is ignored. No extra update and no extra valid pulse results.
- R9: A write (`cfg_we_i` high) goes to channel `cfg_chan_i`. Field codes are 0 = step, 1 = phase, 2 = amplitude, and code 3 changes nothing. Writes take effect at the next update. After phase P is written, the next sample uses P + step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample strobe |
| cfg_we_i | input | 1 | Register write enable |
| cfg_chan_i | input | 2 | Channel selected by the write |
| cfg_field_i | input | 2 | 0 step, 1 phase, 2 amplitude, 3 none |
| cfg_data_i | input | 16 | Write data |
| sample0_o | output | 16 | Channel 0 sample, signed |
| sample1_o | output | 16 | Channel 1 sample, signed |
| sample2_o | output | 16 | Channel 2 sample, signed |
| sample3_o | output | 16 | Channel 3 sample, signed |
| valid_o | output | 1 | One-clock pulse when all four samples are new |

## Verification
The bench steers a channel to index 255 to test the blend across the table seam. A design without the duplicate end entry would read past the table there and jump. Descending table stretches give negative differences, where floor and truncate disagree by one LSB; a design that truncates toward zero fails on exactly those samples. Negative and zero amplitudes, all-ones and zero steps, and phase wrap-around are all driven. A design that truncates the amplitude, treats it as unsigned or fails to hold a phase would show it on these runs. Strobes repeated during an update, including one on the last channel's edge, catch a design that restarts or emits a second valid pulse.

// File: rtl/quad_sine_dds.sv
module quad_sine_dds #(
  parameter int          IDX_W    = 8,
  parameter logic [15:0] STEP_RST = 16'd1000,
  parameter logic [15:0] MAG_RST  = 16'h7FFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_chan_i,
  input  logic [1:0]         cfg_field_i,
  input  logic [15:0]        cfg_data_i,
  output logic signed [15:0] sample0_o,
  output logic signed [15:0] sample1_o,
  output logic signed [15:0] sample2_o,
  output logic signed [15:0] sample3_o,
  output logic               valid_o
);
  localparam int NCH    = 4;
  localparam int FRAC_W = 16 - IDX_W;
  localparam int DEPTH  = (1 << IDX_W) + 1;
  localparam int OFF_W  = $clog2(DEPTH * 16);
  localparam logic [1:0] FLD_STEP  = 2'd0;
  localparam logic [1:0] FLD_PHASE = 2'd1;
  localparam logic [1:0] FLD_MAG   = 2'd2;
  localparam logic [NCH*16-1:0] START_PH = {16'h8000, 16'h4000, 16'h0000, 16'hC000};

  function automatic logic [DEPTH*16-1:0] build_rom();
    logic [DEPTH*16-1:0] t;
    t = '0;
    for (int k = 0; k < DEPTH; k++) begin
      real v;
      v = 32767.0 * $sin(6.283185307179586 * k / (1 << IDX_W));
      t[k*16 +: 16] = 16'($rtoi(v >= 0.0 ? v + 0.5 : v - 0.5));
    end
    return t;
  endfunction

  localparam logic [DEPTH*16-1:0] ROM = build_rom();

  function automatic logic signed [15:0] sat16(input logic signed [33:0] v);
    logic signed [15:0] r;
    if (v > 34'sd32767)       r = 16'sh7FFF;
    else if (v < -34'sd32768) r = 16'sh8000;
    else                      r = v[15:0];
    return r;
  endfunction

  logic              busy;
  logic [1:0]        ch;
  logic [15:0]       phase_q [NCH];
  logic [15:0]       step_q  [NCH];
  logic signed [15:0] mag_q  [NCH];
  logic signed [15:0] out_q  [NCH];

  logic [15:0]        ph_nx;
  logic [IDX_W-1:0]   idx;
  logic [15:0]        frac;
  logic [OFF_W-1:0]   off_a, off_b;
  logic signed [15:0] ent_a, ent_b, interp, res;
  logic signed [16:0] diff;
  logic signed [33:0] p_int, p_mag;

  assign ph_nx  = phase_q[ch] + step_q[ch];
  assign idx    = ph_nx[15:FRAC_W];
  assign frac   = 16'(ph_nx[FRAC_W-1:0]) << (15 - FRAC_W);
  assign off_a  = OFF_W'(idx) << 4;
  assign off_b  = off_a + OFF_W'(16);
  assign ent_a  = ROM[off_a +: 16];
  assign ent_b  = ROM[off_b +: 16];
  assign diff   = 17'(ent_b) - 17'(ent_a);
  assign p_int  = 34'(diff) * 34'($signed({1'b0, frac}));
  assign interp = sat16((p_int >>> 15) + 34'(ent_a));
  assign p_mag  = 34'(interp) * 34'(mag_q[ch]);
  assign res    = sat16(p_mag >>> 15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      ch      <= 2'd0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!busy) begin
        if (tick_i) begin
          busy <= 1'b1;
          ch   <= 2'd0;
        end
      end else begin
        ch <= ch + 2'd1;
        if (ch == 2'd3) begin
          busy    <= 1'b0;
          valid_o <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        phase_q[c] <= START_PH[c*16 +: 16];
        step_q[c]  <= STEP_RST;
        mag_q[c]   <= MAG_RST;
        out_q[c]   <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (busy && ch == 2'(c)) begin
          phase_q[c] <= ph_nx;
          out_q[c]   <= res;
        end else if (cfg_we_i && cfg_chan_i == 2'(c) && cfg_field_i == FLD_PHASE) begin
          phase_q[c] <= cfg_data_i;
        end
        if (cfg_we_i && cfg_chan_i == 2'(c) && cfg_field_i == FLD_STEP) step_q[c] <= cfg_data_i;
        if (cfg_we_i && cfg_chan_i == 2'(c) && cfg_field_i == FLD_MAG)  mag_q[c]  <= cfg_data_i;
      end
    end
  end

  assign sample0_o = out_q[0];
  assign sample1_o = out_q[1];
  assign sample2_o = out_q[2];
  assign sample3_o = out_q[3];

  logic [63:0] out_flat;
  assign out_flat = {out_q[3], out_q[2], out_q[1], out_q[0]};

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_valid_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($past(busy) && $past(ch) == 2'd3));

  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ch != 2'd3) |=> (busy && ch == $past(ch) + 2'd1));

  assert_interp_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((interp >= ent_a && interp <= ent_b) || (interp <= ent_a && interp >= ent_b)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tick_i) |=> $stable(out_flat));
endmodule

// File: tb/quad_sine_dds_bench.sv
`timescale 1ns/1ps
module quad_sine_dds_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_chan = '0;
  logic [1:0] cfg_field = '0;
  logic [15:0] cfg_data = '0;
  logic signed [15:0] s0, s1, s2, s3;
  logic vld;

  always #2.5 clk = ~clk;

  quad_sine_dds u_quad_sine_dds (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cfg_we_i(cfg_we),
    .cfg_chan_i(cfg_chan), .cfg_field_i(cfg_field), .cfg_data_i(cfg_data),
    .sample0_o(s0), .sample1_o(s1), .sample2_o(s2), .sample3_o(s3), .valid_o(vld)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int tbl [257];
  int m_ph [4];
  int m_st [4];
  int m_mag [4];
  int q_s [$];
  string q_r [$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fdiv(longint n, longint d);
    if (n >= 0) return int'(n / d);
    return int'(-((-n + d - 1) / d));
  endfunction

  function automatic int clamp(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  // R3 blend, R4 amplitude scaling, R5 table
  function automatic int expect_smp(int ph, int mag);
    int idx, f, a, b, it;
    idx = ph >> 8;
    f   = ph & 255;
    a   = tbl[idx];
    b   = tbl[idx + 1];
    it  = clamp(longint'(a) + fdiv(longint'(b - a) * f, 256));
    return clamp(fdiv(longint'(it) * mag, 32768));
  endfunction

  function automatic int sext(int d);
    return (d >= 32768) ? d - 65536 : d;
  endfunction

  always @(negedge clk) begin
    if (rst_n && vld) begin
      if (q_s.size() < 4) begin
        chk(1'b0, "R7 R8 unexpected valid pulse", 1, 0);
      end else begin
        for (int c = 0; c < 4; c++) begin
          int e, a;
          string r;
          e = q_s.pop_front();
          r = q_r.pop_front();
          case (c)
            0: a = s0;
            1: a = s1;
            2: a = s2;
            default: a = s3;
          endcase
          chk(a == e, r, a, e);
        end
      end
    end
  end

  task automatic push_expected(string req);
    for (int c = 0; c < 4; c++) begin
      m_ph[c] = (m_ph[c] + m_st[c]) & 16'hFFFF;
      q_s.push_back(expect_smp(m_ph[c], m_mag[c]));
      q_r.push_back(req);
    end
  endtask

  task automatic cfg_write(int c, int f, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_chan = 2'(c); cfg_field = 2'(f); cfg_data = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
    case (f)
      0: m_st[c] = d;
      1: m_ph[c] = d;
      2: m_mag[c] = sext(d);
      default: ;
    endcase
  endtask

  task automatic do_tick(string req, int hold);
    push_expected(req);
    @(negedge clk);
    tick = 1'b1;
    repeat (hold) @(negedge clk);
    tick = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic tick_timed(string req);
    push_expected(req);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk(vld == 1'b0, "R7 valid early after edge 1", int'(vld), 0);
    repeat (3) @(negedge clk);
    chk(vld == 1'b0, "R7 valid early after edge 3", int'(vld), 0);
    @(negedge clk);
    chk(vld == 1'b1, "R7 valid after edge 4", int'(vld), 1);
    @(negedge clk);
    chk(vld == 1'b0, "R7 valid longer than one clock", int'(vld), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 257; k++) begin
      real v;
      v = 32767.0 * $sin(6.283185307179586 * k / 256.0);
      tbl[k] = $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
    end
    m_ph[0] = 16'hC000; m_ph[1] = 16'h0000; m_ph[2] = 16'h4000; m_ph[3] = 16'h8000;
    for (int c = 0; c < 4; c++) begin
      m_st[c] = 1000;
      m_mag[c] = 32767;
    end

    repeat (3) @(negedge clk);
    chk(vld == 1'b0, "R1 valid in reset", int'(vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vld == 1'b0, "R1 valid after reset", int'(vld), 0);
    chk(s0 == 0 && s1 == 0, "R1 samples 0/1 after reset", int'(s0) + int'(s1), 0);
    chk(s2 == 0 && s3 == 0, "R1 samples 2/3 after reset", int'(s2) + int'(s3), 0);

    // R6 quadrature start, R1 default step and amplitude
    tick_timed("R6 R1 first update");
    for (int n = 0; n < 80; n++) do_tick("R2 R3 default run with wrap", 1);

    cfg_write(0, 0, 16'h0123);
    cfg_write(1, 0, 16'h1000);
    cfg_write(2, 0, 16'h7FFF);
    cfg_write(3, 0, 16'hFFFF);
    for (int n = 0; n < 40; n++) do_tick("R9 R2 new steps", 1);

    cfg_write(0, 1, 16'hFF00);
    cfg_write(0, 0, 16'h0080);
    cfg_write(1, 1, 16'h2345);
    cfg_write(1, 0, 16'h0000);
    cfg_write(2, 2, 16'h8000);
    cfg_write(3, 2, 16'h0000);
    do_tick("R5 seam index 255, R2 step zero, R4 negative and zero amplitude", 1);
    do_tick("R2 step zero holds, R5 seam", 1);
    for (int n = 0; n < 12; n++) do_tick("R4 amplitude sweep", 1);

    cfg_write(0, 3, 16'h1234);
    cfg_write(1, 3, 16'h0000);
    do_tick("R9 field code 3 changes nothing", 1);

    cfg_write(1, 2, 16'h4000);
    cfg_write(1, 0, 16'h0155);
    cfg_write(2, 2, 16'hC000);
    cfg_write(3, 2, 16'h7FFF);
    cfg_write(3, 0, 16'h0F0F);
    for (int n = 0; n < 30; n++) do_tick("R3 R4 floor rounding on descending slopes", 1);

    do_tick("R8 strobe repeated on edge 1", 2);
    do_tick("R8 strobe held through the last channel edge", 5);
    repeat (8) @(negedge clk);
    chk(q_s.size() == 0, "R7 R8 every update produced one valid", q_s.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule